// File: doc/BRIEF.md
# Page Write Buffer Controller

This block gathers the data bytes of one page-programming transfer into a 64-entry page latch and then copies them into a byte-addressed array during a timed busy period. A serial front end that is not part of this block marks the start of an accepted write transfer with a start address. It then presents each received data byte with a strobe. When chip select goes high, it reports that event together with a flag that says whether the transfer stopped exactly after the last bit of a byte.

The busy period runs only when chip select rises on a byte boundary after at least one byte has been loaded. Otherwise the transfer is dropped and the array keeps its contents. While busy, the controller raises a write-in-progress flag and refuses array reads. It writes back only the latch entries that were actually loaded. When the period ends it emits a one-cycle pulse that clears the write enable latch kept elsewhere. The busy length is derived from the clock frequency and the longest write time, both given as parameters.

Top module: `page_commit_ctrl`

## Requirements
- R1: Loading advances only the low 6 bits of the byte offset. A byte following offset 63 lands at offset 0 of the same 64-byte page and overwrites what that entry held.
- R2: A `cs_rise` strobe commits only when `byte_aligned` is 1 and at least one byte has been loaded. Any other rise ends the transfer: `wip` stays 0 and the array is unchanged.
- R3: After a commit, `wip` is 1 from the next cycle for exactly TICKS cycles, where TICKS = max(64, CLK_KHZ*WRITE_US/1000).
- R4: `wel_clear` is a single-cycle pulse, high exactly in the first cycle in which `wip` is 0 again after a busy period.
- R5: Only latch entries loaded during the transfer are written to the array. All other bytes of the page keep their previous values.
- R6: A read request made while `wip` is 1 answers with `rd_nack` on the next cycle and no `rd_ack`. A request made while `wip` is 0 answers with `rd_ack` on the next cycle, with `rd_data` holding the array byte at the requested address.
- R7: Address bit 15 is ignored in both the transfer start address and the read address. Array locations are selected by the low MEM_AW address bits; the default is 10.
- R8: `xfer_start`, `byte_vld` and `cs_rise` have no effect while `wip` is 1.
- R9: Each accepted `xfer_start` empties the page latch and its load mask. Bytes from an abandoned earlier transfer are never written.
- R10: After reset, `wip`, `wel_clear`, `rd_ack` and `rd_nack` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_start | input | 1 | Start of a write transfer, one cycle |
| start_addr | input | 16 | Byte address of the first data byte |
| byte_vld | input | 1 | Data byte strobe |
| byte_data | input | 8 | Data byte |
| cs_rise | input | 1 | Chip select went high, one cycle |
| byte_aligned | input | 1 | Transfer ended right after a whole byte |
| rd_req | input | 1 | Array read request |
| rd_addr | input | 16 | Array read address |
| rd_data | output | 8 | Read data, valid with rd_ack |
| rd_ack | output | 1 | Read accepted, data valid |
| rd_nack | output | 1 | Read refused because busy |
| wip | output | 1 | Write cycle in progress |
| wel_clear | output | 1 | Pulse that clears the write enable latch |

## Verification
The hardest situation to reach is a page that already holds known data and then receives a partial or wrapping transfer. The bench must show that untouched bytes survive and that the last-written value wins on the wrapped offsets. The vector table therefore first fills a whole page, then overlays a short burst, a burst that crosses the page end, and a 70-byte burst. A reference array updated by modulo offset arithmetic is compared to every known byte. Inputs sent during the busy window are produced by stimulus issued right after a commit, and the bench then confirms that no second busy period and no array change follows.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  localparam int unsigned PAGE_BYTES = 64;
  localparam int unsigned OFS_W      = 6;
  localparam int unsigned LADDR_W    = 15;
  localparam int unsigned PAGE_W     = LADDR_W - OFS_W;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_PROG} pwb_state_e;

  // next offset inside the page: carry out of bit 5 is dropped
  function automatic logic [OFS_W-1:0] ofs_step(input logic [OFS_W-1:0] o);
    return o + 1'b1;
  endfunction

  // busy length in clock cycles, never shorter than one copy sweep
  function automatic int unsigned write_ticks(input int unsigned khz,
                                              input int unsigned us);
    longint unsigned t;
    t = (longint'(khz) * longint'(us)) / 1000;
    if (t < PAGE_BYTES) t = PAGE_BYTES;
    return int'(t);
  endfunction
endpackage

// File: rtl/pwb_page_latch.sv
module pwb_page_latch
  import pwb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [OFS_W-1:0] wr_ofs,
  input  logic [7:0]       wr_data,
  input  logic [OFS_W-1:0] rd_ofs,
  output logic [7:0]       rd_data,
  output logic             rd_loaded,
  output logic             any_loaded
);
  logic [7:0]            lat_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      mask_q <= '0;
      for (int i = 0; i < int'(PAGE_BYTES); i++) lat_q[i] <= '0;
    end else if (wr_en) begin
      lat_q[wr_ofs]  <= wr_data;
      mask_q[wr_ofs] <= 1'b1;
    end
  end

  assign rd_data    = lat_q[rd_ofs];
  assign rd_loaded  = mask_q[rd_ofs];
  assign any_loaded = |mask_q;
endmodule

// File: rtl/pwb_cycle_timer.sv
module pwb_cycle_timer #(
  parameter int unsigned TICKS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic last,
  output logic done
);
  localparam int unsigned CW = $clog2(TICKS + 1);
  logic [CW-1:0] cnt_q;

  assign last = busy && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      cnt_q <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy  <= 1'b1;
        cnt_q <= CW'(TICKS - 1);
      end else if (busy) begin
        if (cnt_q == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pwb_array_ram.sv
module pwb_array_ram #(
  parameter int unsigned AW = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int unsigned DEPTH = 1 << AW;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/page_commit_ctrl.sv
module page_commit_ctrl
  import pwb_pkg::*;
#(
  parameter int unsigned CLK_KHZ  = 250000,
  parameter int unsigned WRITE_US = 5000,
  parameter int unsigned MEM_AW   = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        xfer_start,
  input  logic [15:0] start_addr,
  input  logic        byte_vld,
  input  logic [7:0]  byte_data,
  input  logic        cs_rise,
  input  logic        byte_aligned,
  input  logic        rd_req,
  input  logic [15:0] rd_addr,
  output logic [7:0]  rd_data,
  output logic        rd_ack,
  output logic        rd_nack,
  output logic        wip,
  output logic        wel_clear
);
  localparam int unsigned CYCLE_TICKS = write_ticks(CLK_KHZ, WRITE_US);

  pwb_state_e         state_q;
  logic [PAGE_W-1:0]  page_q;
  logic [OFS_W-1:0]   ofs_q;
  logic               copy_on_q;
  logic [OFS_W-1:0]   copy_idx_q;

  // named internal events
  logic in_load, accept_start, byte_take, commit_go, abort_evt;
  logic tmr_last;
  logic lat_byte_ok, lat_any;
  logic [7:0] lat_byte;
  logic mem_we;
  logic [LADDR_W-1:0] copy_laddr;
  logic rd_go;

  assign in_load      = (state_q == ST_LOAD);
  assign accept_start = xfer_start && !wip;
  assign byte_take    = in_load && byte_vld && !xfer_start;
  assign commit_go    = in_load && cs_rise && !xfer_start && byte_aligned
                        && (lat_any || byte_take);
  assign abort_evt    = in_load && cs_rise && !xfer_start && !commit_go;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_LOAD: begin
          if (accept_start)   state_q <= ST_LOAD;
          else if (commit_go) state_q <= ST_PROG;
          else if (abort_evt) state_q <= ST_IDLE;
        end
        ST_PROG: if (tmr_last) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q <= '0;
      ofs_q  <= '0;
    end else if (accept_start) begin
      page_q <= start_addr[LADDR_W-1:OFS_W];
      ofs_q  <= start_addr[OFS_W-1:0];
    end else if (byte_take) begin
      ofs_q <= ofs_step(ofs_q);
    end
  end

  pwb_page_latch u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (accept_start),
    .wr_en      (byte_take),
    .wr_ofs     (ofs_q),
    .wr_data    (byte_data),
    .rd_ofs     (copy_idx_q),
    .rd_data    (lat_byte),
    .rd_loaded  (lat_byte_ok),
    .any_loaded (lat_any)
  );

  pwb_cycle_timer #(.TICKS(CYCLE_TICKS)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (commit_go),
    .busy  (wip),
    .last  (tmr_last),
    .done  (wel_clear)
  );

  // copy sweep: one latch entry per cycle, inside the busy window
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      copy_on_q  <= 1'b0;
      copy_idx_q <= '0;
    end else if (commit_go) begin
      copy_on_q  <= 1'b1;
      copy_idx_q <= '0;
    end else if (copy_on_q) begin
      copy_idx_q <= ofs_step(copy_idx_q);
      if (copy_idx_q == OFS_W'(PAGE_BYTES - 1)) copy_on_q <= 1'b0;
    end
  end

  assign mem_we     = copy_on_q && lat_byte_ok;
  assign copy_laddr = {page_q, copy_idx_q};
  assign rd_go      = rd_req && !wip;

  pwb_array_ram #(.AW(MEM_AW)) u_ram (
    .clk   (clk),
    .we    (mem_we),
    .waddr (copy_laddr[MEM_AW-1:0]),
    .wdata (lat_byte),
    .re    (rd_go),
    .raddr (rd_addr[MEM_AW-1:0]),
    .rdata (rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ack  <= 1'b0;
      rd_nack <= 1'b0;
    end else begin
      rd_ack  <= rd_go;
      rd_nack <= rd_req && wip;
    end
  end

  logic unused_hi;
  assign unused_hi = ^{start_addr[15], rd_addr[15:MEM_AW], copy_laddr};
endmodule

// File: rtl/pwb_checker.sv
module pwb_checker #(
  parameter int unsigned TICKS = 64
) (
  input logic clk,
  input logic rst_n,
  input logic wip,
  input logic wel_clear,
  input logic rd_req,
  input logic rd_ack,
  input logic rd_nack,
  input logic cs_rise,
  input logic byte_aligned,
  input logic commit_go,
  input logic mem_we
);
  logic [31:0] run_q;
  always_ff @(posedge clk) begin
    if (!rst_n)   run_q <= '0;
    else if (wip) run_q <= run_q + 1;
    else          run_q <= '0;
  end

  p_busy_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> (run_q == TICKS));
  p_busy_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wip |-> (run_q < TICKS));
  p_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit_go |=> wip);
  p_welclr_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> wel_clear);
  p_welclr_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clear |-> $fell(wip));
  p_abort_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wip && cs_rise && !byte_aligned) |=> !wip);
  p_nack_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && wip) |=> (rd_nack && !rd_ack));
  p_ack_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !wip) |=> (rd_ack && !rd_nack));
  p_write_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> wip);
endmodule

bind page_commit_ctrl pwb_checker #(.TICKS(CYCLE_TICKS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wip          (wip),
  .wel_clear    (wel_clear),
  .rd_req       (rd_req),
  .rd_ack       (rd_ack),
  .rd_nack      (rd_nack),
  .cs_rise      (cs_rise),
  .byte_aligned (byte_aligned),
  .commit_go    (commit_go),
  .mem_we       (mem_we)
);

// File: tb/page_commit_ctrl_test.sv
module page_commit_ctrl_test;
  localparam int TICKS = 250;   // max(64, 250000*1/1000)

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xfer_start = 1'b0, byte_vld = 1'b0, cs_rise = 1'b0, byte_aligned = 1'b0;
  logic rd_req = 1'b0;
  logic [15:0] start_addr = '0, rd_addr = '0;
  logic [7:0] byte_data = '0, rd_data;
  logic rd_ack, rd_nack, wip, wel_clear;

  always #2ns clk = ~clk;

  page_commit_ctrl #(.CLK_KHZ(250000), .WRITE_US(1), .MEM_AW(10)) uut (
    .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .start_addr(start_addr),
    .byte_vld(byte_vld), .byte_data(byte_data), .cs_rise(cs_rise),
    .byte_aligned(byte_aligned), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_ack(rd_ack), .rd_nack(rd_nack), .wip(wip),
    .wel_clear(wel_clear));

  int n_run = 0, n_bad = 0;
  logic [7:0] ref_mem [1024];
  bit         known   [1024];

  typedef struct packed {
    logic [15:0] a; logic [7:0] n; logic [7:0] d; logic al;
  } vec_t;
  localparam vec_t VECS [6] = '{
    '{16'h0040, 8'd64, 8'h10, 1'b1},  // R5 full page
    '{16'h0050, 8'd3,  8'hA0, 1'b1},  // R5 partial
    '{16'h007E, 8'd5,  8'h30, 1'b1},  // R1 wrap
    '{16'h0044, 8'd4,  8'h55, 1'b0},  // R2 misaligned abort
    '{16'h8040, 8'd2,  8'h77, 1'b1},  // R7 bit 15 set
    '{16'h0100, 8'd70, 8'h01, 1'b1}   // R1 70 bytes
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ref_apply(input logic [15:0] a, input int n, input logic [7:0] d);
    for (int i = 0; i < n; i++) begin
      int idx;
      idx = ((a[9:0] & 10'h3C0) + ((a[5:0] + i) % 64)) % 1024;
      ref_mem[idx] = 8'(d + i);
      known[idx]   = 1'b1;
    end
  endtask

  // inputs change at negedge; one transfer ends on the negedge after cs_rise
  task automatic do_xfer(input logic [15:0] a, input int n, input logic [7:0] d,
                         input logic al);
    xfer_start = 1'b1; start_addr = a;
    @(negedge clk); xfer_start = 1'b0;
    for (int i = 0; i < n; i++) begin
      byte_vld = 1'b1; byte_data = 8'(d + i);
      @(negedge clk);
    end
    byte_vld = 1'b0;
    cs_rise = 1'b1; byte_aligned = al;
    @(negedge clk); cs_rise = 1'b0; byte_aligned = 1'b0;
  endtask

  task automatic wait_idle(output int cnt);
    cnt = 0;
    while (wip && cnt < 1000) begin cnt++; @(negedge clk); end
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d,
                    output logic ack, output logic nack);
    rd_req = 1'b1; rd_addr = a;
    @(negedge clk); rd_req = 1'b0;
    d = rd_data; ack = rd_ack; nack = rd_nack;
  endtask

  task automatic check_page(input logic [15:0] base, input string tag);
    logic [7:0] d; logic ack, nack;
    for (int o = 0; o < 64; o++) begin
      int idx;
      idx = (base[9:0] & 10'h3C0) + o;
      if (known[idx]) begin
        rd(16'(idx), d, ack, nack);
        chk(ack === 1'b1 && d === ref_mem[idx], tag, int'(d), int'(ref_mem[idx]));
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    int cnt;
    logic [7:0] d; logic ack, nack;
    for (int i = 0; i < 1024; i++) begin known[i] = 1'b0; ref_mem[i] = '0; end
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(wip === 1'b0 && wel_clear === 1'b0, "R10 reset wip/wel_clear", int'({wip, wel_clear}), 0);
    chk(rd_ack === 1'b0 && rd_nack === 1'b0, "R10 reset rd_ack/rd_nack", int'({rd_ack, rd_nack}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    foreach (VECS[v]) begin
      do_xfer(VECS[v].a, int'(VECS[v].n), VECS[v].d, VECS[v].al);
      if (VECS[v].al) begin
        ref_apply(VECS[v].a, int'(VECS[v].n), VECS[v].d);
        wait_idle(cnt);
        chk(cnt == TICKS, "R3 busy length", cnt, TICKS);
        chk(wel_clear === 1'b1, "R4 wel_clear on wip fall", int'(wel_clear), 1);
        @(negedge clk);
        chk(wel_clear === 1'b0, "R4 wel_clear single cycle", int'(wel_clear), 0);
      end else begin
        repeat (3) @(negedge clk);
        chk(wip === 1'b0, "R2 misaligned rise leaves wip low", int'(wip), 0);
      end
      check_page(VECS[v].a, "R1/R2/R5/R7 page contents");
    end

    // R7: read address bit 15 ignored
    rd(16'h8041, d, ack, nack);
    chk(ack === 1'b1 && d === ref_mem[10'h041], "R7 read alias", int'(d), int'(ref_mem[10'h041]));

    // R6 and R8: stimulus while busy
    do_xfer(16'h0060, 1, 8'hC3, 1'b1);
    ref_apply(16'h0060, 1, 8'hC3);
    rd(16'h0060, d, ack, nack);
    chk(nack === 1'b1 && ack === 1'b0, "R6 read refused while busy", int'({ack, nack}), 1);
    do_xfer(16'h0048, 2, 8'hEE, 1'b1);   // ignored, R8
    wait_idle(cnt);
    repeat (5) @(negedge clk);
    chk(wip === 1'b0, "R8 no second busy period", int'(wip), 0);
    check_page(16'h0040, "R8 busy-time transfer ignored");

    // R9: latch cleared on restart
    do_xfer(16'h0200, 64, 8'h80, 1'b1);
    ref_apply(16'h0200, 64, 8'h80);
    wait_idle(cnt);
    xfer_start = 1'b1; start_addr = 16'h0200;
    @(negedge clk); xfer_start = 1'b0;
    for (int i = 0; i < 3; i++) begin
      byte_vld = 1'b1; byte_data = 8'h5A; @(negedge clk);
    end
    byte_vld = 1'b0;
    do_xfer(16'h0210, 1, 8'h99, 1'b1);
    ref_apply(16'h0210, 1, 8'h99);
    wait_idle(cnt);
    check_page(16'h0200, "R9 abandoned bytes not written");

    // R2: aligned rise with no byte loaded
    do_xfer(16'h0300, 0, 8'h00, 1'b1);
    repeat (3) @(negedge clk);
    chk(wip === 1'b0, "R2 empty transfer does not commit", int'(wip), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule